// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire management bus of external PHY and switch devices. It issues clause-22 read and write frames. Software programs it through six 32-bit registers on a simple write-strobe bus. A frame is started by a register write, and its progress is followed by polling a flag word. The management clock MDC is made from the system clock by a divider. The divider ratio comes from a small code that software picks to suit the system clock frequency.

A write frame starts when software writes the 16-bit value into the data register, after the device and register numbers have been loaded. A read frame starts when software moves bit 0 of the command register from 0 to 1. The returned value is then collected from the status register once the flag word shows that the frame is finished and the data is valid. The configuration register has a management reset bit. Software pulses this bit to abandon a frame and put the bus back to idle.

Top module: `mdio_master`

## Requirements
- R1: After rst_n is released, every register reads as 0, MDC is low and MDIO is not driven (mdio_oe = 0).
- R2: The register map is: 0x20 configuration (bit 31 management reset, bits 3:0 divider code), 0x24 command (bit 0), 0x28 address (device number in bits 12:8, register number in bits 4:0), 0x2C write data (bits 15:0), 0x30 read status (bits 15:0), 0x34 flags. Unlisted bits read as 0.
- R3: Writing 0x2C while idle sends a 64-bit frame, MSB first: 32 ones, 01, opcode 01, the 5-bit device number, the 5-bit register number, 10, and the 16 data bits. MDIO is driven for the whole frame.
- R4: A read starts only on a 0-to-1 change of command bit 0. Writing 1 while the bit already holds 1 starts nothing.
- R5: A read frame drives 32 ones, 01, opcode 10, the device number and the register number. It releases MDIO for the last 18 bits (turnaround and data). It samples 16 data bits MSB first on rising MDC edges, and puts them in bits 15:0 of 0x30.
- R6: In 0x34, bit 0 (busy) is 1 from the start of a frame until its last MDC falling edge. Bit 2 (invalid) is 1 from the start of a read until its data is in 0x30.
- R7: Each MDC bit is a low half then a high half. Each half lasts H system clocks, with H = 2, 3, 4, 6, 40, 35, 30, 44 for codes 0, 1, 2, 3, 4, 5, 7, 9, and H = 50 for any other code. This keeps MDC at or below 2.5 MHz for codes 4, 5, 7 and 9 on 200, 175, 150 and 220 MHz clocks. MDC is low when idle.
- R8: While busy, writes to 0x24, 0x28 and 0x2C are ignored. They change no field and neither restart nor alter the frame in flight.
- R9: A write to 0x20 with bit 31 set stops any frame at that same edge: busy and invalid go to 0, MDC goes low and MDIO is released. No frame starts while bit 31 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value sampled from the line |

## Verification
Two functions can meet in the same cycle: a management-reset write to the configuration register, and a sequencer that is part-way through a frame and advancing MDC. The bench provokes this by starting a write frame and issuing the reset write a few dozen clocks later, while MDC is toggling. It judges the result by checking, at the very next sample, that busy is 0, MDC is low and MDIO is released. It also checks that a data-register write made while the reset bit is held starts nothing, and that a clean frame follows once the bit is cleared. A second overlap covered is a register write that arrives during a frame: after the frame ends, the address and data fields and the captured frame bits must all show the original values.

// File: rtl/mdio_master.sv
module mdio_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [7:0] A_CFG = 8'h20, A_CMD = 8'h24, A_ADR = 8'h28,
                         A_DAT = 8'h2C, A_STS = 8'h30, A_IND = 8'h34;
  localparam int FRAME = 64;
  localparam int RELEASE_AT = 46;
  localparam int DATA_AT = 48;

  function automatic logic [7:0] half_len(input logic [3:0] code);
    case (code)
      4'd0: return 8'd2;
      4'd1: return 8'd3;
      4'd2: return 8'd4;
      4'd3: return 8'd6;
      4'd4: return 8'd40;
      4'd5: return 8'd35;
      4'd7: return 8'd30;
      4'd9: return 8'd44;
      default: return 8'd50;
    endcase
  endfunction

  logic        cfg_rst, cmd0, busy, rd, inval, half;
  logic [3:0]  div;
  logic [4:0]  phy, regn;
  logic [15:0] wd, rdat, rx;
  logic [5:0]  bitn;
  logic [7:0]  cnt;
  logic [63:0] sh;

  wire w_cfg = reg_wr && reg_addr == A_CFG;
  wire w_cmd = reg_wr && reg_addr == A_CMD;
  wire w_adr = reg_wr && reg_addr == A_ADR;
  wire w_dat = reg_wr && reg_addr == A_DAT;
  wire abort = cfg_rst || (w_cfg && reg_wdata[31]);
  wire go_w  = w_dat && !busy && !abort;
  wire go_r  = w_cmd && reg_wdata[0] && !cmd0 && !busy && !abort;
  wire [7:0] hl = half_len(div);
  wire tick  = cnt == 8'd0;

  wire [63:0] frame_w = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, regn, 2'b10, reg_wdata[15:0]};
  wire [63:0] frame_r = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, regn, 18'h3FFFF};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rst <= 1'b0; div <= '0; cmd0 <= 1'b0; phy <= '0; regn <= '0;
      wd <= '0; rdat <= '0; rx <= '0; busy <= 1'b0; rd <= 1'b0;
      inval <= 1'b0; half <= 1'b0; bitn <= '0; cnt <= '0; sh <= '0;
    end else begin
      if (w_cfg) begin
        cfg_rst <= reg_wdata[31];
        div     <= reg_wdata[3:0];
      end
      if (w_adr && !busy) begin
        phy  <= reg_wdata[12:8];
        regn <= reg_wdata[4:0];
      end
      if (w_dat && !busy) wd <= reg_wdata[15:0];
      if (w_cmd && !busy) cmd0 <= reg_wdata[0];

      if (abort) begin
        busy  <= 1'b0;
        half  <= 1'b0;
        inval <= 1'b0;
      end else if (go_w || go_r) begin
        busy  <= 1'b1;
        rd    <= go_r;
        inval <= go_r;
        sh    <= go_r ? frame_r : frame_w;
        bitn  <= '0;
        half  <= 1'b0;
        cnt   <= hl - 8'd1;
      end else if (busy) begin
        if (!tick) begin
          cnt <= cnt - 8'd1;
        end else begin
          cnt  <= hl - 8'd1;
          half <= !half;
          if (!half) begin
            if (rd && bitn >= 6'(DATA_AT)) rx <= {rx[14:0], mdio_i};
          end else begin
            if (bitn == 6'(FRAME - 1)) begin
              busy <= 1'b0;
              if (rd) begin
                rdat  <= rx;
                inval <= 1'b0;
              end
            end
            bitn <= bitn + 6'd1;
            sh   <= {sh[62:0], 1'b0};
          end
        end
      end
    end
  end

  assign mdc     = busy && half;
  assign mdio_o  = sh[63];
  assign mdio_oe = busy && (!rd || bitn < 6'(RELEASE_AT));

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {cfg_rst, 27'b0, div};
      A_CMD:   reg_rdata = {31'b0, cmd0};
      A_ADR:   reg_rdata = {19'b0, phy, 3'b0, regn};
      A_DAT:   reg_rdata = {16'b0, wd};
      A_STS:   reg_rdata = {16'b0, rdat};
      A_IND:   reg_rdata = {29'b0, inval, 1'b0, busy};
      default: reg_rdata = 32'b0;
    endcase
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        inval,
  input logic        rd,
  input logic [4:0]  phy,
  input logic [4:0]  regn
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R7
  AST_INVALID_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    inval |-> (busy && rd)); // R6
  AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd && !mdio_oe) |=> !mdio_oe); // R5
  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 8'h28) |=> ($stable(phy) && $stable(regn))); // R8
  AST_FRAME_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdio_oe && mdio_o)); // R3
  AST_RESET_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h20 && reg_wdata[31]) |=> (!busy && !mdc)); // R9
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .inval(inval), .rd(rd), .phy(phy), .regn(regn)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_master u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // responder: watches MDC at negedge clk
  int          edge_n = 0;
  int          st0 = 0, st1 = 0;
  logic [63:0] cap, capoe;
  logic [15:0] resp;
  logic        prev_mdc = 1'b0;
  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      if (edge_n < 64) begin
        cap[63-edge_n]   = mdio_o;
        capoe[63-edge_n] = mdio_oe;
      end
      if (edge_n == 0) st0 = cyc;
      if (edge_n == 1) st1 = cyc;
      edge_n = edge_n + 1;
    end
    if (!mdc && prev_mdc) begin
      if (edge_n == 47) mdio_i = 1'b0;
      else if (edge_n >= 48 && edge_n < 64) mdio_i = resp[63-edge_n];
      else mdio_i = 1'b1;
    end
    prev_mdc = mdc;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rdreg(8'h34, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  function automatic int exp_half(input logic [3:0] c);
    case (c)
      4'd0: return 2;  4'd1: return 3;  4'd2: return 4;  4'd3: return 6;
      4'd4: return 40; 4'd5: return 35; 4'd7: return 30; 4'd9: return 44;
      default: return 50;
    endcase
  endfunction

  // {read, div[3:0], phy[4:0], reg[4:0], data[15:0]}
  localparam logic [30:0] VEC [5] = '{
    {1'b0, 4'd0, 5'h01, 5'h00, 16'hA5C3},
    {1'b1, 4'd1, 5'h1F, 5'h1F, 16'h8001},
    {1'b0, 4'd2, 5'h10, 5'h0A, 16'hFFFF},
    {1'b1, 4'd3, 5'h00, 5'h01, 16'h3C96},
    {1'b1, 4'd4, 5'h04, 5'h1D, 16'h5A0F}
  };

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] fw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdreg(8'h34, v); chk("R1 flags", v, 0);
    rdreg(8'h20, v); chk("R1 config", v, 0);
    rdreg(8'h28, v); chk("R1 address", v, 0);
    chk("R1 mdc/oe", {mdc, mdio_oe}, 0);

    // R2 field positions
    wr(8'h28, 32'hFFFF_FFFF); rdreg(8'h28, v); chk("R2 address fields", v, 32'h0000_1F1F);
    wr(8'h20, 32'h8000_00F3); rdreg(8'h20, v); chk("R2 config fields", v, 32'h8000_0003);
    wr(8'h20, 32'h0);

    // table walk: R3 R5 R6 R7
    foreach (VEC[i]) begin
      logic        isrd;
      logic [3:0]  dv;
      logic [4:0]  ph, rg;
      logic [15:0] dt;
      {isrd, dv, ph, rg, dt} = VEC[i];
      wr(8'h20, 32'h8000_0000 | 32'(dv));
      wr(8'h20, 32'(dv));
      wr(8'h24, 32'h0);
      wr(8'h28, {19'b0, ph, 3'b0, rg});
      resp = dt; edge_n = 0;
      if (isrd) wr(8'h24, 32'h1); else wr(8'h2C, 32'(dt));
      rdreg(8'h34, v);
      chk("R6 flags mid-frame", v, isrd ? 32'h5 : 32'h1);
      wait_idle();
      rdreg(8'h34, v); chk("R6 flags after frame", v, 0);
      chk("R7 MDC period", 64'(st1 - st0), 64'(2 * exp_half(dv)));
      chk("R3/R5 edge count", 64'(edge_n), 64);
      if (isrd) begin
        chk("R5 driven header", cap[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, ph, rg});
        chk("R5 oe pattern", capoe, {46'h3FFF_FFFF_FFFF, 18'h0});
        rdreg(8'h30, v); chk("R5 read data", v, 32'(dt));
      end else begin
        chk("R3 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, dt});
        chk("R3 oe pattern", capoe, 64'hFFFF_FFFF_FFFF_FFFF);
      end
    end

    // R4: command bit already 1 -> no new read
    wr(8'h24, 32'h1);
    rdreg(8'h34, v); chk("R4 no restart on 1->1", v, 0);
    wr(8'h24, 32'h0); wr(8'h24, 32'h1);
    rdreg(8'h34, v); chk("R4 start on 0->1", v, 32'h5);
    wait_idle();

    // R8: writes ignored while busy
    wr(8'h20, 32'h0);
    wr(8'h28, {19'b0, 5'h0C, 3'b0, 5'h03});
    edge_n = 0;
    wr(8'h2C, 32'h1234);
    wr(8'h28, 32'h0000_1F1F);
    wr(8'h2C, 32'hBEEF);
    wr(8'h24, 32'h0);
    wait_idle();
    rdreg(8'h28, v); chk("R8 address held", v, 32'h0000_0C03);
    rdreg(8'h2C, v); chk("R8 data held", v, 32'h1234);
    rdreg(8'h24, v); chk("R8 command held", v, 32'h1);
    fw = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0C, 5'h03, 2'b10, 16'h1234};
    chk("R8 frame unaltered", cap, fw);

    // R9: management reset during a frame
    wr(8'h2C, 32'h0F0F);
    repeat (40) @(negedge clk);
    wr(8'h20, 32'h8000_0000);
    chk("R9 abort mdc/oe", {mdc, mdio_oe}, 0);
    rdreg(8'h34, v); chk("R9 abort busy", v, 0);
    wr(8'h2C, 32'h7777);
    rdreg(8'h34, v); chk("R9 no start while held", v, 0);
    wr(8'h20, 32'h0);
    edge_n = 0;
    wr(8'h2C, 32'h4321);
    wait_idle();
    chk("R9 clean frame after release", cap,
        {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0C, 5'h03, 2'b10, 16'h4321});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule